// File: doc/BRIEF.md
# Skewable output data latch stage

This block is the output stage for an 8-bit memory data bus. Outgoing data is registered on the rising edge of the main memory clock. The stage can also pass that registered value through a transparent latch gated by a separate auxiliary output clock. That clock is a copy of the main clock delayed by no more than the main clock's high time. When the latch is in the path, the bus pins keep their previous value until the auxiliary clock rises, so the output hold time after the main clock edge grows by the skew.

The stage decides whether to use the latch from the auxiliary input itself. After reset is released it watches that input for a fixed window of main clock cycles. A clock that toggles puts the latch into the path. An input tied high, which is the unconnected default, or tied low keeps the plain registered path. The decision is frozen at the end of the window and holds until the next reset. When the bus-mode select chooses strobed operation, the latch is bypassed whatever was detected. Incoming data is never timed by the auxiliary clock.

Top module: `skew_out_stage`

## Requirements
- R1: While `rst` is high, `dout` reads 0 from the first main clock rising edge onward, and the stage is in registered (main-clock-only) mode.
- R2: In registered mode, `dout` changes only at a `clk` rising edge and then shows the value `din` had at that edge. This holds with `aux_clk` held high or held low throughout.
- R3: Each rising edge of `aux_clk` counts as one transition. If 2 or more transitions are seen within the 8 `clk` cycles after reset is released, latch mode is selected. If fewer are seen, registered mode is selected.
- R4: In latch mode, `dout` follows the registered value while `aux_clk` is high. At a `clk` edge, `dout` keeps the previous value until `aux_clk` rises and then shows the new one.
- R5: In latch mode, while `aux_clk` stays low, `dout` keeps its value even though `din` and the registered value change.
- R6: The mode is fixed after the 8-cycle window and stays fixed until the next reset. `aux_clk` activity that starts after the window does not select latch mode.
- R7: With `strobe_mode` = 1 (strobed bus mode), the latch is bypassed and `dout` behaves as in R2 even when `aux_clk` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main memory clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aux_clk | input | 1 | Skewed auxiliary output clock, asynchronous to the logic; latch gate |
| strobe_mode | input | 1 | 1 = strobed bus mode (latch bypassed), 0 = clocked bus mode |
| din | input | 8 | Internal data to be driven on the bus |
| dout | output | 8 | Memory data bus pins |

## Verification
The assertions assume that `din` and `strobe_mode` change only away from the rising edge of `clk`. They also assume that `aux_clk` is either static or a copy of `clk` delayed by less than its high time. The bench therefore drives data at the falling edge and produces the auxiliary clock as a pulse that rises 1 ns after each main edge and falls 2.5 ns later. `strobe_mode` changes only while reset is held. The bench uses single pulses of the auxiliary clock, placed inside the window or after it, to test the transition-count threshold and the freezing of the mode.

// File: rtl/skew_out_pkg.sv
package skew_out_pkg;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_WINDOW    = 8;
    localparam int DEF_MIN_EDGES = 2;
    localparam int DEF_SYNC      = 2;

    typedef enum logic {
        SRC_MAIN  = 1'b0,
        SRC_LATCH = 1'b1
    } out_src_e;
endpackage

// File: rtl/aux_edge_sync.sv
module aux_edge_sync #(
    parameter int SYNC_STAGES = skew_out_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic aux_clk,
    output logic edge_seen
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
    } sync_t;

    logic  tog_q;
    sync_t s_d, s_q;

    // flips once per auxiliary rising edge, so a clock of the same rate is seen
    always_ff @(posedge aux_clk or posedge rst) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= ~tog_q;
    end

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[SYNC_STAGES-2:0], tog_q};
        s_d.prev = s_q.sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign edge_seen = s_q.sh[SYNC_STAGES-1] ^ s_q.prev;
endmodule

// File: rtl/toggle_detect.sv
module toggle_detect
    import skew_out_pkg::*;
#(
    parameter int WINDOW    = DEF_WINDOW,
    parameter int MIN_EDGES = DEF_MIN_EDGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     edge_seen,
    output logic     done,
    output out_src_e src
);
    localparam int WIN_W  = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(MIN_EDGES);

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [EDGE_W-1:0] edges;
        logic              done;
        out_src_e          src;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (!det_q.done) begin
            if (edge_seen && det_q.edges != EDGE_MAX)
                det_d.edges = det_q.edges + 1'b1;
            if (det_q.win == WIN_LAST) begin
                det_d.done = 1'b1;
                det_d.src  = (det_q.edges >= EDGE_MAX) ? SRC_LATCH : SRC_MAIN;
            end else begin
                det_d.win = det_q.win + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q.win   <= '0;
            det_q.edges <= '0;
            det_q.done  <= 1'b0;
            det_q.src   <= SRC_MAIN;
        end else begin
            det_q <= det_d;
        end
    end

    assign done = det_q.done;
    assign src  = det_q.src;
endmodule

// File: rtl/out_register.sv
module out_register #(
    parameter int DATA_W = skew_out_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] reg_out
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } oreg_t;

    oreg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.data = din;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign reg_out = r_q.data;
endmodule

// File: rtl/out_latch.sv
module out_latch #(
    parameter int DATA_W = skew_out_pkg::DEF_DATA_W
) (
    input  logic              gate_en,
    input  logic              use_latch,
    input  logic [DATA_W-1:0] reg_in,
    output logic [DATA_W-1:0] pin_out
);
    logic [DATA_W-1:0] lat_q;

    always_latch begin
        if (gate_en) lat_q <= reg_in;
    end

    assign pin_out = use_latch ? lat_q : reg_in;
endmodule

// File: rtl/skew_out_stage.sv
module skew_out_stage
    import skew_out_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int WINDOW      = DEF_WINDOW,
    parameter int MIN_EDGES   = DEF_MIN_EDGES,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aux_clk,
    input  logic              strobe_mode,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic              edge_seen;
    logic              det_done;
    out_src_e          det_src;
    logic              det_latch;
    logic              use_latch;
    logic [DATA_W-1:0] reg_out;

    aux_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst       (rst),
        .aux_clk   (aux_clk),
        .edge_seen (edge_seen)
    );

    toggle_detect #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) i_det (
        .clk       (clk),
        .rst       (rst),
        .edge_seen (edge_seen),
        .done      (det_done),
        .src       (det_src)
    );

    out_register #(.DATA_W(DATA_W)) i_reg (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .reg_out (reg_out)
    );

    assign det_latch = (det_src == SRC_LATCH);
    assign use_latch = det_latch && !strobe_mode;

    out_latch #(.DATA_W(DATA_W)) i_lat (
        .gate_en   (rst | aux_clk),
        .use_latch (use_latch),
        .reg_in    (reg_out),
        .pin_out   (dout)
    );
endmodule

// File: rtl/skew_out_chk.sv
module skew_out_chk #(
    parameter int DATA_W = 8,
    parameter int WINDOW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              done,
    input logic              latch_mode,
    input logic              use_latch
);
    localparam int CW = $clog2(WINDOW + 2);
    localparam logic [CW-1:0] CMAX = CW'(WINDOW + 1);

    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)               cyc_q <= '0;
        else if (cyc_q != CMAX) cyc_q <= cyc_q + 1'b1;
    end

    // R1: output cleared while reset holds
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (!rst || dout == '0));

    // R2: registered path shows the data captured at the previous edge
    p_main_path_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !use_latch && $past(!use_latch)) |-> (dout == $past(din)));

    // R3: decision lands exactly at the end of the window
    p_window_end_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= CW'(WINDOW)) == done);

    // R6: mode does not move once decided
    p_mode_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> $stable(latch_mode));
endmodule

bind skew_out_stage skew_out_chk #(.DATA_W(DATA_W), .WINDOW(WINDOW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .dout       (dout),
    .done       (det_done),
    .latch_mode (det_latch),
    .use_latch  (use_latch)
);

// File: tb/test_skew_out_stage.sv
`timescale 1ns/100ps
module test_skew_out_stage;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       aux_clk = 1'b1;
    logic       strobe_mode = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;

    logic       aux_run = 1'b0;
    logic       aux_level = 1'b1;
    logic       mon_on = 1'b0;
    logic       exp_latch = 1'b0;
    logic       have_prev = 1'b0;
    logic [7:0] prev_v = 8'h00;
    logic [7:0] exp_q[$];
    int         total = 0;
    int         bad = 0;
    logic       finished = 1'b0;
    string      cur_req = "R2";

    skew_out_stage i_skew_out_stage (
        .clk(clk), .rst(rst), .aux_clk(aux_clk),
        .strobe_mode(strobe_mode), .din(din), .dout(dout)
    );

    always #2.5 clk = ~clk;

    // auxiliary clock: skewed 1 ns behind clk, high for 2.5 ns, or a static level
    always begin
        @(posedge clk);
        if (aux_run) begin
            #1   aux_clk = 1'b1;
            #2.5 aux_clk = 1'b0;
        end else begin
            aux_clk = aux_level;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop the item captured at this edge and compare
    always begin
        logic [7:0] v;
        @(posedge clk);
        if (mon_on && exp_q.size() > 0) begin
            v = exp_q.pop_front();
            #0.5;
            if (exp_latch) begin
                if (have_prev) check(dout == prev_v, "R4 hold-before-aux", dout, prev_v);
            end else begin
                check(dout == v, cur_req, dout, v);
            end
            #1.5;
            check(dout == v, exp_latch ? "R4 after-aux" : cur_req, dout, v);
            prev_v    = v;
            have_prev = 1'b1;
        end
    end

    task automatic burst(input int n, input logic [7:0] seed);
        have_prev = 1'b0;
        mon_on    = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            din = seed ^ 8'(i * 37);
            exp_q.push_back(din);
        end
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        mon_on = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 8'hA5;
        repeat (4) @(negedge clk);
        check(dout == 8'h00, "R1 reset clears", dout, 0);
        rst = 1'b0;
    endtask

    initial begin
        // static high, as when unconnected
        aux_run = 1'b0; aux_level = 1'b1;
        do_reset();
        repeat (12) @(negedge clk);
        exp_latch = 1'b0; cur_req = "R2 aux high";
        burst(10, 8'h3C);

        // static low
        aux_level = 1'b0;
        do_reset();
        repeat (12) @(negedge clk);
        cur_req = "R2 aux low";
        burst(10, 8'hC3);

        // toggling clock selects the latch
        aux_run = 1'b1;
        do_reset();
        repeat (12) @(negedge clk);
        exp_latch = 1'b1;
        burst(12, 8'h5A);

        // stop aux low: output holds while data moves
        begin
            logic [7:0] held;
            aux_run = 1'b0; aux_level = 1'b0;
            repeat (2) @(negedge clk);
            held = dout;
            din = held ^ 8'hFF;
            repeat (3) @(negedge clk);
            check(dout == held, "R5 hold while aux low", dout, held);
            din = held ^ 8'h0F;
            repeat (2) @(negedge clk);
            check(dout == held, "R5 hold after new din", dout, held);
            aux_level = 1'b1;
            repeat (2) @(negedge clk);
            check(dout == (held ^ 8'h0F), "R4 transparent on aux high", dout, held ^ 8'h0F);
        end

        // mode stays latch after a static spell (R6)
        aux_run = 1'b1;
        repeat (2) @(negedge clk);
        exp_latch = 1'b1;
        burst(6, 8'h99);

        // one transition in the window: below threshold (R3)
        aux_run = 1'b0; aux_level = 1'b0;
        do_reset();
        aux_run = 1'b1;
        @(negedge clk); aux_run = 1'b0;
        repeat (12) @(negedge clk);
        exp_latch = 1'b0; cur_req = "R3 one edge stays main";
        burst(6, 8'h11);

        // two transitions in the window: latch (R3)
        do_reset();
        aux_run = 1'b1;
        @(negedge clk); aux_run = 1'b0;
        @(negedge clk); aux_run = 1'b1;
        @(negedge clk); aux_run = 1'b0;
        repeat (10) @(negedge clk);
        aux_run = 1'b1;
        repeat (2) @(negedge clk);
        exp_latch = 1'b1;
        burst(6, 8'h22);

        // toggling starts only after the window: frozen main (R6)
        aux_run = 1'b0; aux_level = 1'b0;
        do_reset();
        repeat (12) @(negedge clk);
        aux_run = 1'b1;
        repeat (2) @(negedge clk);
        exp_latch = 1'b0; cur_req = "R6 late toggle stays main";
        burst(8, 8'h44);

        // strobed mode bypasses the latch (R7)
        @(negedge clk); rst = 1'b1; strobe_mode = 1'b1;
        do_reset();
        repeat (12) @(negedge clk);
        exp_latch = 1'b0; cur_req = "R7 strobed bypass";
        burst(8, 8'h77);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule